// File: doc/BRIEF.md
# I2S Stereo Serial Audio Port

This block is a full-duplex serial audio port that uses I2S framing. Each stereo frame carries two channel words, and each word can be 1 to 24 bits long. The port receives a serial stream and turns it into a left and a right parallel word, marked by a one-cycle valid strobe. At the same time it sends a pair of parallel words back out as a serial stream.

The port can own the serial timing or follow it:
- **Clock master:** it divides the system clock to make the bit clock, and it toggles word-select after a programmable number of bit periods per channel.
- **Slave:** it takes bit clock and word-select from the link.

All serial lines are brought into the system clock domain through two-flop synchronizers. All framing is then decided from the detected bit-clock edges. This means the bit clock may stop for any length of time, or keep running through unused slots, after a channel's LSB. Framing is not lost in either case.

Configuration is static while the port runs and is changed only under reset:
- `cfg_master_i` picks the role.
- `cfg_width_i` sets the sample width.
- `cfg_slots_i` sets the bit periods per channel that the master generates.

In slave mode, each phase of `sclk_i` must last at least 3 system clocks. `HALF_DIV` must be at least 4.

Top module: `i2s_port`

## Requirements
- R1: With `cfg_master_i`=1, `sclk_o` toggles every `HALF_DIV` system clocks. `ws_o` changes only together with a falling `sclk_o`, and it changes once every `cfg_slots_i` rising edges of `sclk_o`. With `cfg_master_i`=0, `sclk_o` and `ws_o` stay low and the port is timed from `sclk_i`/`ws_i`.
- R2: Word-select is sampled on rising bit-clock edges. Word-select 0 means channel A (left) and 1 means channel B (right). The first rising edge that shows a new word-select value starts that channel, and the channel's MSB falls in the following bit period.
- R3: The serial input is sampled on rising bit-clock edges, MSB first. Exactly `cfg_width_i` bits (1..24) are taken per channel. Bits after the LSB, up to the next word-select change, are ignored.
- R4: After the channel-B LSB is captured, `rx_valid_o` is high for exactly one system clock. At that point `rx_left_o` holds the A word and `rx_right_o` holds the B word of the same frame, both right-justified with zero upper bits. A B word with no complete A word before it gives no pulse, and the outputs change only with a pulse.
- R5: `sd_o` changes only after a falling bit-clock edge. It sends the word MSB first and drives 0 in every bit period after the LSB until the next word starts.
- R6: `tx_left_i` and `tx_right_i` are latched together at the start of channel A. The left word is sent in channel A and the right word in channel B. Changes to these inputs at any other time have no effect on the frame in progress.
- R7: A bit clock that stops after a channel's LSB, for any duration, does not change any received or transmitted word. The same holds for a bit clock that runs for extra slack periods after the LSB.
- R8: When the bit periods per channel equal the sample width, the LSB falls in the period in which word-select changes. It is still transferred correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_master_i | input | 1 | 1: generate bit clock and word-select; 0: follow the link |
| cfg_width_i | input | CW | Sample width in bits, 1..MAX_W |
| cfg_slots_i | input | SLOT_W | Bit periods per channel in master mode, not less than the width |
| sclk_i | input | 1 | Bit clock from the link (slave) |
| ws_i | input | 1 | Word-select from the link (slave) |
| sd_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Generated bit clock (master), low in slave mode |
| ws_o | output | 1 | Generated word-select (master), low in slave mode |
| sd_o | output | 1 | Serial data out |
| tx_left_i | input | MAX_W | Channel A word to send, right-justified |
| tx_right_i | input | MAX_W | Channel B word to send, right-justified |
| rx_left_o | output | MAX_W | Received channel A word |
| rx_right_o | output | MAX_W | Received channel B word |
| rx_valid_o | output | 1 | One-cycle strobe for a new received pair |

## Verification
The hardest case to reach from the ports is a bit clock that halts right after an LSB, or keeps ticking through slack. It is hardest when the halt coincides with slot counts equal to the width, because then the LSB shares its period with the word-select change.

The bench drives the link itself in slave mode and parks the bit clock high after every LSB period. The park length varies from frame to frame and channel to channel. The bench drives ones on the data line during slack periods and scrambles the transmit words at every falling edge. A wrong framing choice therefore shows up in the received pairs or in the sampled serial output.

A sweep over widths from 1 to 24, with slot counts equal to the width and three larger, covers both layouts. Master runs add the check of the generated clock and word-select timing.

// File: rtl/i2s_pkg.sv
package i2s_pkg;
  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;
endpackage

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen #(
  parameter int HALF_DIV = 4,
  parameter int SLOT_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SLOT_W-1:0] slots_i,
  output logic              sclk_o,
  output logic              ws_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0]     div_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      slot_q <= '0;
      sclk_o <= 1'b0;
      ws_o   <= 1'b0;
    end else if (!en_i) begin
      div_q  <= '0;
      slot_q <= '0;
      sclk_o <= 1'b0;
      ws_o   <= 1'b0;
    end else if (div_q == DIV_LAST) begin
      div_q  <= '0;
      sclk_o <= ~sclk_o;
      if (sclk_o) begin
        // falling edge: count one bit period, flip word-select at slot end
        if (slot_q == slots_i - 1'b1) begin
          slot_q <= '0;
          ws_o   <= ~ws_o;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2s_sync.sv
module i2s_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic ws_o,
  output logic sd_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int N = 3;

  logic [N-1:0] raw;
  logic [N-1:0] s1_q, s2_q;
  logic         sclk_d_q;

  assign raw = {sd_i, ws_i, sclk_i};

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= raw[i];
        s2_q[i] <= s1_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= s2_q[0];
  end

  assign ws_o   = s2_q[1];
  assign sd_o   = s2_q[2];
  assign rise_o = s2_q[0] & ~sclk_d_q;
  assign fall_o = ~s2_q[0] & sclk_d_q;
endmodule

// File: rtl/i2s_frame.sv
module i2s_frame
  import i2s_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rise_i,
  input  logic  ws_i,
  output logic  start_o,
  output chan_e chan_o
);
  logic seen_q;
  logic ws_q;

  assign start_o = rise_i & seen_q & (ws_i != ws_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      ws_q   <= 1'b0;
      chan_o <= CH_A;
    end else if (rise_i) begin
      seen_q <= 1'b1;
      ws_q   <= ws_i;
      if (start_o) chan_o <= chan_e'(ws_i);
    end
  end
endmodule

// File: rtl/i2s_rx.sv
module i2s_rx
  import i2s_pkg::*;
#(
  parameter int MAX_W = 24,
  parameter int CW    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             sd_i,
  input  logic             start_i,
  input  chan_e            chan_i,
  input  logic [CW-1:0]    width_i,
  output logic [MAX_W-1:0] left_o,
  output logic [MAX_W-1:0] right_o,
  output logic             valid_o
);
  logic [MAX_W-1:0] sh_q, sh_n, a_q;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             active_q, a_ok_q;
  logic             take, done;

  assign sh_n  = {sh_q[MAX_W-2:0], sd_i};
  assign cnt_n = cnt_q + 1'b1;
  assign take  = active_q && (cnt_q < width_i);
  assign done  = take && (cnt_n == width_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      a_q      <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      a_ok_q   <= 1'b0;
      left_o   <= '0;
      right_o  <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i) begin
        // bit of the current channel first, then a possible new channel
        if (take) begin
          sh_q  <= sh_n;
          cnt_q <= cnt_n;
        end
        if (done) begin
          if (chan_i == CH_A) begin
            a_q    <= sh_n;
            a_ok_q <= 1'b1;
          end else if (a_ok_q) begin
            left_o  <= a_q;
            right_o <= sh_n;
            valid_o <= 1'b1;
            a_ok_q  <= 1'b0;
          end
        end
        if (start_i) begin
          sh_q     <= '0;
          cnt_q    <= '0;
          active_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
  import i2s_pkg::*;
#(
  parameter int MAX_W = 24,
  parameter int CW    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             start_i,
  input  logic             ws_i,
  input  chan_e            chan_i,
  input  logic [CW-1:0]    width_i,
  input  logic [MAX_W-1:0] left_i,
  input  logic [MAX_W-1:0] right_i,
  output logic             sd_o
);
  logic [MAX_W-1:0] shl_q, shr_q, cur_q, word;
  logic [CW-1:0]    rem_q;
  logic             pend_q;

  assign word = (chan_i == CH_A) ? shl_q : shr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shl_q  <= '0;
      shr_q  <= '0;
      cur_q  <= '0;
      rem_q  <= '0;
      pend_q <= 1'b0;
      sd_o   <= 1'b0;
    end else begin
      if (start_i) begin
        pend_q <= 1'b1;
        if (!ws_i) begin
          shl_q <= left_i;
          shr_q <= right_i;
        end
      end else if (fall_i) begin
        pend_q <= 1'b0;
        if (pend_q) begin
          cur_q <= word;
          sd_o  <= word[width_i - 1'b1];
          rem_q <= width_i - 1'b1;
        end else if (rem_q != '0) begin
          sd_o  <= cur_q[rem_q - 1'b1];
          rem_q <= rem_q - 1'b1;
        end else begin
          sd_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/i2s_port.sv
module i2s_port
  import i2s_pkg::*;
#(
  parameter int MAX_W    = 24,
  parameter int SLOT_W   = 6,
  parameter int HALF_DIV = 4,
  localparam int CW      = $clog2(MAX_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_master_i,
  input  logic [CW-1:0]     cfg_width_i,
  input  logic [SLOT_W-1:0] cfg_slots_i,
  input  logic              sclk_i,
  input  logic              ws_i,
  input  logic              sd_i,
  output logic              sclk_o,
  output logic              ws_o,
  output logic              sd_o,
  input  logic [MAX_W-1:0]  tx_left_i,
  input  logic [MAX_W-1:0]  tx_right_i,
  output logic [MAX_W-1:0]  rx_left_o,
  output logic [MAX_W-1:0]  rx_right_o,
  output logic              rx_valid_o
);
  logic  line_sclk, line_ws;
  logic  ws_s, sd_s, rise_evt, fall_evt;
  logic  frm_start;
  chan_e frm_chan;

  i2s_bclk_gen #(.HALF_DIV(HALF_DIV), .SLOT_W(SLOT_W)) u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_master_i),
    .slots_i(cfg_slots_i),
    .sclk_o (sclk_o),
    .ws_o   (ws_o)
  );

  // master timing goes through the same synchronizer as the slave inputs
  assign line_sclk = cfg_master_i ? sclk_o : sclk_i;
  assign line_ws   = cfg_master_i ? ws_o   : ws_i;

  i2s_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sclk_i(line_sclk),
    .ws_i  (line_ws),
    .sd_i  (sd_i),
    .ws_o  (ws_s),
    .sd_o  (sd_s),
    .rise_o(rise_evt),
    .fall_o(fall_evt)
  );

  i2s_frame u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise_evt),
    .ws_i   (ws_s),
    .start_o(frm_start),
    .chan_o (frm_chan)
  );

  i2s_rx #(.MAX_W(MAX_W), .CW(CW)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise_evt),
    .sd_i   (sd_s),
    .start_i(frm_start),
    .chan_i (frm_chan),
    .width_i(cfg_width_i),
    .left_o (rx_left_o),
    .right_o(rx_right_o),
    .valid_o(rx_valid_o)
  );

  i2s_tx #(.MAX_W(MAX_W), .CW(CW)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (fall_evt),
    .start_i(frm_start),
    .ws_i   (ws_s),
    .chan_i (frm_chan),
    .width_i(cfg_width_i),
    .left_i (tx_left_i),
    .right_i(tx_right_i),
    .sd_o   (sd_o)
  );
endmodule

// File: rtl/i2s_port_chk.sv
module i2s_port_chk #(
  parameter int MAX_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_master_i,
  input logic             sclk_o,
  input logic             ws_o,
  input logic             sd_o,
  input logic             rx_valid_o,
  input logic [MAX_W-1:0] rx_left_o,
  input logic [MAX_W-1:0] rx_right_o,
  input logic             rise_evt_i,
  input logic             fall_evt_i
);
  p_slave_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_master_i && !$past(cfg_master_i)) |-> (!sclk_o && !ws_o));

  p_ws_on_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ws_o != $past(ws_o)) |-> ($past(sclk_o) && !sclk_o));

  p_sclk_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |=> sclk_o);

  p_valid_after_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(rise_evt_i));

  p_valid_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_rx_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rx_left_o != $past(rx_left_o)) || (rx_right_o != $past(rx_right_o))) |-> rx_valid_o);

  p_sd_after_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_o != $past(sd_o)) |-> $past(fall_evt_i));
endmodule

bind i2s_port i2s_port_chk #(.MAX_W(MAX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_master_i(cfg_master_i),
  .sclk_o      (sclk_o),
  .ws_o        (ws_o),
  .sd_o        (sd_o),
  .rx_valid_o  (rx_valid_o),
  .rx_left_o   (rx_left_o),
  .rx_right_o  (rx_right_o),
  .rise_evt_i  (rise_evt),
  .fall_evt_i  (fall_evt)
);

// File: tb/tb_i2s_port.sv
`timescale 1ns/1ps
module tb_i2s_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 4;
  localparam int SH         = 6;   // slave half period in clocks
  localparam int MAX_W      = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_master = 1'b0;
  logic [4:0]  cfg_width = 5'd8;
  logic [5:0]  cfg_slots = 6'd8;
  logic        sclk_i = 1'b1, ws_i = 1'b1, sd_i = 1'b0;
  logic        sclk_o, ws_o, sd_o;
  logic [23:0] tx_left = '0, tx_right = '0;
  logic [23:0] rx_left, rx_right;
  logic        rx_valid;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_port #(.MAX_W(MAX_W), .SLOT_W(6), .HALF_DIV(HALF_DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_master_i(cfg_master),
    .cfg_width_i(cfg_width), .cfg_slots_i(cfg_slots),
    .sclk_i(sclk_i), .ws_i(ws_i), .sd_i(sd_i),
    .sclk_o(sclk_o), .ws_o(ws_o), .sd_o(sd_o),
    .tx_left_i(tx_left), .tx_right_i(tx_right),
    .rx_left_o(rx_left), .rx_right_o(rx_right), .rx_valid_o(rx_valid)
  );

  task automatic chk(bit ok, string req, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h (w=%0d s=%0d m=%0b)",
               req, act, exp, cfg_width, cfg_slots, cfg_master);
    end
  endtask

  function automatic logic [23:0] word_of(int k, int c, int w, bit is_rx);
    logic [31:0] v;
    v = k * 32'h0001_9E37 + c * 32'h0007_F4A1 + (is_rx ? 32'h00A5_3C96 : 32'h0035_C9A1);
    v = v ^ (v >> 7);
    if (k == 1) v = '1;
    if (k == 2 && c == 1) v = '0;
    return v[23:0] & ((24'h1 << w) - 24'h1);
  endfunction

  // far-end model of the link, in the system clock domain
  logic line_sclk, line_ws;
  assign line_sclk = cfg_master ? sclk_o : sclk_i;
  assign line_ws   = cfg_master ? ws_o   : ws_i;

  int  m_hp, m_tog, m_rises, m_frame, m_cap_cnt, m_out_cnt, m_chan, rx_seen;
  bit  m_prev, m_seen, m_wsq, m_started, slave_drive;
  logic [23:0] m_cap, tmpw;

  always @(negedge clk) begin
    int w;
    w = int'(cfg_width);
    if (!rst_n) begin
      m_prev = line_sclk; m_hp = 0; m_tog = 0; m_rises = 0; m_frame = -1;
      m_cap_cnt = 0; m_out_cnt = 0; m_chan = 0; rx_seen = 0;
      m_seen = 0; m_wsq = 0; m_started = 0; m_cap = '0;
    end else if (!done) begin
      m_hp++;
      if (!cfg_master && (sclk_o || ws_o)) slave_drive = 1;
      if (line_sclk != m_prev) begin
        if (cfg_master && m_tog > 0) chk(m_hp == HALF_DIV, "R1 half period", 48'(m_hp), 48'(HALF_DIV));
        m_tog++; m_hp = 0;
        if (line_sclk) begin
          m_rises++;
          if (m_started) begin
            if (m_cap_cnt < w) begin
              m_cap = {m_cap[22:0], sd_o};
              m_cap_cnt++;
              if (m_cap_cnt == w && m_frame >= 0)
                chk(m_cap == word_of(m_frame, m_chan, w, 0), "R5 R6 R7 R8 tx word",
                    48'(m_cap), 48'(word_of(m_frame, m_chan, w, 0)));
            end else begin
              chk(sd_o == 1'b0, "R5 slack zero", 48'(sd_o), 48'd0);
            end
          end
          if (m_seen && line_ws != m_wsq) begin
            if (cfg_master && m_started) chk(m_rises == int'(cfg_slots), "R1 slots per channel",
                                             48'(m_rises), 48'(cfg_slots));
            m_rises = 0; m_started = 1; m_chan = int'(line_ws);
            m_cap_cnt = 0; m_cap = '0; m_out_cnt = 0;
            if (!line_ws) begin  // R2: low selects channel A, new frame
              m_frame++;
              tx_left  = word_of(m_frame, 0, w, 0);
              tx_right = word_of(m_frame, 1, w, 0);
            end
          end
          m_seen = 1; m_wsq = line_ws;
        end else begin
          if (m_started && m_out_cnt < w) begin
            tmpw = word_of(m_frame, m_chan, w, 1);
            sd_i = tmpw[w-1-m_out_cnt];
            m_out_cnt++;
          end else begin
            sd_i = 1'b1;  // R3: garbage in slack must be ignored
          end
          // R6: scribble the transmit inputs away from the latch point
          tx_left  = ~tx_left;
          tx_right = tx_right ^ 24'h5A5A5A;
        end
      end
      m_prev = line_sclk;
      if (rx_valid) begin
        chk({rx_left, rx_right} == {word_of(rx_seen, 0, w, 1), word_of(rx_seen, 1, w, 1)},
            "R2 R3 R4 R7 rx pair", {rx_left, rx_right},
            {word_of(rx_seen, 0, w, 1), word_of(rx_seen, 1, w, 1)});
        rx_seen++;
      end
    end
  end

  task automatic apply_cfg(bit m, int w, int s);
    rst_n = 1'b0;
    cfg_master = m; cfg_width = 5'(w); cfg_slots = 6'(s);
    sclk_i = 1'b1; ws_i = 1'b1; slave_drive = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({rx_valid, sd_o, sclk_o, ws_o} == 4'b0, "R4 R5 reset outputs",
        48'({rx_valid, sd_o, sclk_o, ws_o}), 48'd0);
    chk({rx_left, rx_right} == 48'd0, "R4 reset words", {rx_left, rx_right}, 48'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic period(bit v);
    repeat (SH) @(posedge clk);
    #1 sclk_i = 1'b0; ws_i = v;
    repeat (SH) @(posedge clk);
    #1 sclk_i = 1'b1;
  endtask

  task automatic run_slave(int w, int s, int nf);
    apply_cfg(0, w, s);
    period(1'b1);
    period(1'b0);  // first word-select change: channel A starts
    for (int f = 0; f < nf; f++) begin
      for (int c = 0; c < 2; c++) begin
        for (int p = 0; p < s; p++) begin
          period((p == s - 1) ? bit'(c == 0) : bit'(c));
          if (p == w - 1) repeat (((f * 5 + c * 3 + w) % 4) * 7) @(posedge clk);  // R7 stop
        end
      end
    end
    period(1'b0);
    period(1'b0);
    repeat (10) @(posedge clk);
    chk(rx_seen == nf, "R4 R7 pair count", 48'(rx_seen), 48'(nf));
    chk(slave_drive == 0, "R1 slave outputs low", 48'(slave_drive), 48'd0);
  endtask

  task automatic run_master(int w, int s, int nf);
    apply_cfg(1, w, s);
    while (rx_seen < nf) @(posedge clk);
    repeat (4) @(posedge clk);
    chk(rx_seen == nf, "R4 master pair count", 48'(rx_seen), 48'(nf));
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    int ws_list [10] = '{1, 2, 3, 7, 8, 13, 16, 20, 23, 24};
    foreach (ws_list[i]) begin
      run_slave(ws_list[i], ws_list[i], 3);      // R8 layout
      run_slave(ws_list[i], ws_list[i] + 3, 3);  // slack periods
    end
    run_master(24, 24, 3);
    run_master(16, 20, 3);
    run_master(5, 8, 3);
    run_master(1, 2, 3);
    run_master(12, 32, 3);
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end
endmodule